// File: doc/BRIEF.md
# Clock Gate with Resynchronized Enable

This block turns a free-running clock into a gated clock. The request to run the clock arrives from logic in another clock domain. That logic can also be held in functional reset. A flop clocked by the requester's clock registers the request, and the functional reset clears that flop asynchronously. The flop output goes straight into a chain of flops clocked by the clock being gated, with no logic in between. The last flop of the chain drives the gate. The gate is a latch that is open while the clock is low, followed by an AND with the clock. Because of this, the gated clock only ever shows complete high phases.

Only the power-on reset clears the synchronizer chain and the latch. The functional reset never reaches them directly. When the functional reset is asserted, the request is withdrawn inside the requester's flop, and that change travels through the chain like any other. The clock therefore winds down after two or three edges and never loses a pulse part-way.

The enable must be a level. A request pulse shorter than one requester clock period, or shorter than about three periods of the gated clock, may never show up at the gate. This is accepted behaviour.

Top module: `sync_clock_gate`

## Requirements
- R1: While `por_n` is 0, `en_sync` and `gclk` are 0, whatever the other inputs do.
- R2: While `func_rst_n` is 0, the registered request is 0 and `req_en` has no effect. `en_sync` goes to 0 and `gclk` stops.
- R3: `en_sync` is the registered request delayed by SYNC_STAGES (default 2) rising edges of `clk_in`. If `func_rst_n` falls during a high phase of `clk_in` while `en_sync` is 1, `en_sync` stays 1 after the next rising edge and is 0 after the second one.
- R4: The gate value is taken from `en_sync` while `clk_in` is low and is held through each high phase. With a steady `en_sync` of 1, every `clk_in` cycle gives exactly one `gclk` pulse. With a steady 0, it gives none.
- R5: Every high pulse of `gclk` lasts exactly one high phase of `clk_in`, even when `req_en` and `func_rst_n` toggle at arbitrary times, including during a high phase.
- R6: `gclk` is never high while `clk_in` is low.
- R7: If `en_sync` rises at edge k, there is no `gclk` pulse at edge k and there is one at edge k+1. If `en_sync` falls at edge k, there is a pulse at edge k and none at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_clk | input | 1 | Clock of the requesting domain |
| req_en | input | 1 | Level request to run the gated clock, in the `req_clk` domain |
| clk_in | input | 1 | Free-running clock to be gated |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| func_rst_n | input | 1 | Functional reset of the requesting domain, active low, asynchronous |
| gclk | output | 1 | Gated clock |
| en_sync | output | 1 | Request as seen after the synchronizer, for observation |

## Verification
The assertions assume the following about the inputs:
- `clk_in` runs continuously with an even duty cycle.
- `por_n` changes only during a low phase of `clk_in`.
- The synchronizer flops never go metastable, since simulation resolves every sample cleanly.

The stimulus respects these assumptions. `por_n` is moved only two nanoseconds after a falling edge. `req_en` and `func_rst_n` are toggled at random times, and often in the middle of a high phase, so the pulse-width checks see the gate react at its worst moment.

// File: rtl/sync_cg_pkg.sv
`timescale 1ns/1ps
package sync_cg_pkg;
  // Number of flops resynchronizing the request into the gated domain.
  localparam int unsigned SYNC_STAGES_DEF = 2;
  // Minimum depth that still filters one metastable sample.
  localparam int unsigned SYNC_STAGES_MIN = 2;
endpackage

// File: rtl/cg_req_launch.sv
`timescale 1ns/1ps
// Request register in the requester's domain. The functional reset clears it
// here and nowhere else; its output feeds the synchronizer with no gating.
module cg_req_launch (
  input  logic req_clk,
  input  logic func_rst_n,
  input  logic req_en,
  output logic req_q
);
  always_ff @(posedge req_clk or negedge func_rst_n) begin
    if (!func_rst_n) req_q <= 1'b0;
    else             req_q <= req_en;
  end
endmodule

// File: rtl/cg_sync_chain.sv
`timescale 1ns/1ps
// Flop chain into the gated domain, cleared only by power-on reset.
module cg_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stg[0] <= 1'b0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stg[i] <= 1'b0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/cg_latch_gate.sv
`timescale 1ns/1ps
// Latch open in the low phase, then AND with the clock.
module cg_latch_gate (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  output logic en_held,
  output logic gclk
);
  always_latch begin
    if (!por_n)   en_held = 1'b0;
    else if (!clk) en_held = en;
  end

  assign gclk = clk & en_held;
endmodule

// File: rtl/sync_clock_gate.sv
`timescale 1ns/1ps
module sync_clock_gate
  import sync_cg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic req_clk,
  input  logic req_en,
  input  logic clk_in,
  input  logic por_n,
  input  logic func_rst_n,
  output logic gclk,
  output logic en_sync
);
  localparam int unsigned DEPTH =
    (SYNC_STAGES < SYNC_STAGES_MIN) ? SYNC_STAGES_MIN : SYNC_STAGES;

  logic launch_q;
  logic gate_q;

  cg_req_launch u_launch (
    .req_clk    (req_clk),
    .func_rst_n (func_rst_n),
    .req_en     (req_en),
    .req_q      (launch_q)
  );

  cg_sync_chain #(.STAGES(DEPTH)) u_sync (
    .clk   (clk_in),
    .por_n (por_n),
    .d     (launch_q),
    .q     (en_sync)
  );

  cg_latch_gate u_gate (
    .clk     (clk_in),
    .por_n   (por_n),
    .en      (en_sync),
    .en_held (gate_q),
    .gclk    (gclk)
  );
endmodule

// File: rtl/sync_clock_gate_checker.sv
`timescale 1ns/1ps
module sync_clock_gate_checker (
  input logic clk_in,
  input logic por_n,
  input logic en_sync,
  input logic gate_q,
  input logic gclk
);
  logic gate_at_rise;
  logic armed;

  always_ff @(posedge clk_in) gate_at_rise <= gate_q;

  always_ff @(posedge clk_in or negedge por_n) begin
    if (!por_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: power-on reset keeps the chain output and the latch cleared
  p_por_quiet_r1: assert property (@(posedge clk_in)
    !por_n |-> (!en_sync && !gate_q))
    else $error("p_por_quiet_r1");

  // R4: the latch presents the synchronized request at each rising edge
  p_gate_tracks_r4: assert property (@(posedge clk_in) disable iff (!por_n)
    gate_q == en_sync)
    else $error("p_gate_tracks_r4");

  // R5: the held value does not move during a high phase
  p_gate_steady_high_r5: assert property (@(negedge clk_in) disable iff (!por_n || !armed)
    gate_q == gate_at_rise)
    else $error("p_gate_steady_high_r5");

  // R6: a gated rising edge only happens with the source clock high
  always @(posedge gclk) begin
    if (por_n === 1'b1) begin
      p_gclk_in_high_r6: assert (clk_in === 1'b1)
        else $error("p_gclk_in_high_r6");
    end
  end
endmodule

bind sync_clock_gate sync_clock_gate_checker u_chk (
  .clk_in  (clk_in),
  .por_n   (por_n),
  .en_sync (en_sync),
  .gate_q  (gate_q),
  .gclk    (gclk)
);

// File: tb/sync_clock_gate_bench.sv
`timescale 1ns/1ps
module sync_clock_gate_bench;
  localparam real HALF = 5.0;   // 100 MHz clk_in
  localparam real REQ_HALF = 3.5;

  logic req_clk = 1'b0, clk_in = 1'b0;
  logic req_en, por_n, func_rst_n;
  logic gclk, en_sync;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;
  realtime t_rise;

  sync_clock_gate u_sync_clock_gate (
    .req_clk(req_clk), .req_en(req_en), .clk_in(clk_in), .por_n(por_n),
    .func_rst_n(func_rst_n), .gclk(gclk), .en_sync(en_sync)
  );

  always #(HALF) clk_in = ~clk_in;
  always #(REQ_HALF) req_clk = ~req_clk;

  function automatic int exp_pulses(bit en, int cycles);
    return en ? cycles : 0;
  endfunction

  function automatic real exp_width();
    return HALF;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R5/R6 monitor on every gated pulse
  always @(posedge gclk) begin
    t_rise = $realtime;
    pulses++;
    chk(clk_in === 1'b1, "R6", "gclk rose with clk_in low", int'(clk_in), 1);
  end

  always @(negedge gclk) begin
    real w;
    w = $realtime - t_rise;
    chk((w > exp_width() - 0.001) && (w < exp_width() + 0.001), "R5",
        "pulse width ps", int'(w * 1000.0), int'(exp_width() * 1000.0));
  end

  always @(negedge clk_in) begin
    #2;
    if (por_n === 1'b1 && gclk !== 1'b0)
      chk(1'b0, "R6", "gclk high in low phase", int'(gclk), 0);
  end

  task automatic mid_high();
    @(posedge clk_in); #2;
  endtask

  task automatic mid_low();
    @(negedge clk_in); #2;
  endtask

  task automatic count_window(int n, bit en, string req);
    int p0;
    mid_low();
    p0 = pulses;
    repeat (n) mid_low();
    chk(pulses - p0 == exp_pulses(en, n), req, "pulse count", pulses - p0, exp_pulses(en, n));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    req_en = 1'b1; por_n = 1'b0; func_rst_n = 1'b1;

    // R1: power-on reset holds everything quiet
    repeat (8) mid_high();
    chk(gclk === 1'b0, "R1", "gclk during por", int'(gclk), 0);
    chk(en_sync === 1'b0, "R1", "en_sync during por", int'(en_sync), 0);
    chk(pulses == 0, "R1", "pulses during por", pulses, 0);

    mid_low(); por_n = 1'b1;
    repeat (6) mid_high();
    chk(en_sync === 1'b1, "R3", "en_sync after request", int'(en_sync), 1);
    count_window(10, 1'b1, "R4");

    // R7 falling edge of en_sync
    req_en = 1'b0;
    begin
      int g0 = -1, g1 = -1;
      for (int i = 0; i < 20; i++) begin
        mid_high();
        if (en_sync === 1'b0) begin
          g0 = int'(gclk); mid_high(); g1 = int'(gclk); break;
        end
      end
      chk(g0 == 1, "R7", "pulse at fall edge", g0, 1);
      chk(g1 == 0, "R7", "no pulse after fall edge", g1, 0);
    end
    count_window(10, 1'b0, "R4");

    // R7 rising edge of en_sync
    req_en = 1'b1;
    begin
      int g0 = -1, g1 = -1;
      for (int i = 0; i < 20; i++) begin
        mid_high();
        if (en_sync === 1'b1) begin
          g0 = int'(gclk); mid_high(); g1 = int'(gclk); break;
        end
      end
      chk(g0 == 0, "R7", "no pulse at rise edge", g0, 0);
      chk(g1 == 1, "R7", "pulse after rise edge", g1, 1);
    end

    // R3: functional reset mid-high, synchronizer untouched
    repeat (4) mid_high();
    func_rst_n = 1'b0;
    mid_high();
    chk(en_sync === 1'b1, "R3", "en_sync one edge after func reset", int'(en_sync), 1);
    chk(gclk === 1'b1, "R3", "gclk one edge after func reset", int'(gclk), 1);
    mid_high();
    chk(en_sync === 1'b0, "R3", "en_sync two edges after func reset", int'(en_sync), 0);
    chk(gclk === 1'b1, "R7", "last pulse at fall edge", int'(gclk), 1);
    mid_high();
    chk(gclk === 1'b0, "R7", "gclk stopped", int'(gclk), 0);

    // R2: request ignored under functional reset
    req_en = 1'b0; repeat (3) mid_high(); req_en = 1'b1;
    count_window(12, 1'b0, "R2");
    chk(en_sync === 1'b0, "R2", "en_sync under func reset", int'(en_sync), 0);
    func_rst_n = 1'b1;
    repeat (6) mid_high();
    chk(en_sync === 1'b1, "R2", "en_sync after func release", int'(en_sync), 1);

    // R5: random toggling, pulse widths checked by the monitor
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk_in); #($urandom_range(0, 4));
      end else begin
        #($urandom_range(1, 37));
      end
      if ($urandom_range(0, 1) == 1) req_en = ~req_en;
      if ($urandom_range(0, 4) == 0) func_rst_n = ~func_rst_n;
    end

    // R1: power-on reset again mid-run, in a low phase
    func_rst_n = 1'b1; req_en = 1'b1;
    repeat (6) mid_high();
    chk(en_sync === 1'b1, "R3", "en_sync after random phase", int'(en_sync), 1);
    mid_low(); por_n = 1'b0;
    count_window(6, 1'b0, "R1");
    chk(en_sync === 1'b0, "R1", "en_sync after por reassert", int'(en_sync), 0);
    mid_low(); por_n = 1'b1;
    repeat (6) mid_high();
    count_window(8, 1'b1, "R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule